// File: doc/BRIEF.md
# Stored-Vector Pin Pattern Generator

This block plays back a stored sequence of 64-channel test patterns onto the connector pins of a digital board under test. Each pattern is kept in an external byte-wide static memory of 256K locations. A step's 64-bit pattern occupies eight consecutive locations. The block reads those eight bytes, assembles them in a staging register and then moves the whole pattern onto the pins in one clock edge. It holds that pattern for a programmable number of clock cycles, then moves to the next step. While one step is on the pins, the next pattern is fetched in the background.

The memory bus is shared with a host controller. A two-bit ownership input gives the host the bus when both bits are zero, and gives it to the generator for any other value. While the host owns the bus, the generator drives no address, strobe or bus enable, and its fetches pause.

Before a run the host presents a direction mask, a step period and a step count, then pulses start. A mask bit set to one marks a board output: that channel's driver stays at high impedance and its data line reads zero. The highest channel does not carry pattern data. It is reserved as a step marker that toggles once at every step boundary, so captured responses can be cut into per-step windows. After the programmed number of steps, a done flag rises.

Top module: `vgen_top`

## Requirements
- R1: In reset and after it, before any start, every pin enable is 0, every pin output is 0, done is 0 and no memory read strobe is issued.
- R2: When bus_sel is 2'b00, mem_rd, mem_drive and mem_addr are all 0. For any other bus_sel value, mem_drive is 1.
- R3: Step k (counting from 0) places memory byte 8k+b on channels 8b to 8b+7, with the byte's bit 0 on channel 8b. Channels 0 to 62 carry these bits, and all of them change in the same cycle as the marker toggle.
- R4: A dir_mask bit of 1 makes that channel's pin_oe 0 and its pin_out 0. A bit of 0 makes pin_oe 1 and pin_out equal to the pattern bit. Channel 63 always has pin_oe 1 once the first step is on the pins.
- R5: Channel 63 toggles exactly once at the start of every step, including the first, and never toggles at any other time.
- R6: With the bus owned throughout, every step except the last lasts max(P', 10) cycles, where P' is the programmed period with 0 treated as 1. No step is ever shorter than 10 cycles.
- R7: If the host takes the bus for H cycles, beginning in the first cycle of a step that needs a prefetch, that step lasts H+10 cycles. The next step still carries the correct pattern.
- R8: Nothing is driven and no memory is read until start is pulsed. The direction mask, period and step count are sampled at start. A start pulse or a change of dir_mask during a run has no effect on that run.
- R9: done falls in the cycle after an accepted start. It rises P' cycles after the last step appears, and the pins then hold the last pattern and marker. A start with a step count of 0 raises done at once, with no marker toggle and no fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 2 | Memory bus ownership, 2'b00 = host |
| start | input | 1 | Start pulse for a run |
| dir_mask | input | 63 | Channel direction, 1 = board output (not driven) |
| period | input | 16 | Cycles per step |
| nsteps | input | 16 | Number of steps in the run |
| mem_addr | output | 18 | Memory address while the generator owns the bus |
| mem_rd | output | 1 | Memory read strobe |
| mem_drive | output | 1 | Enable for the generator's bus drivers |
| mem_rdata | input | 8 | Memory read data, valid the cycle after the strobe |
| pin_out | output | 64 | Channel data, bit 63 = step marker |
| pin_oe | output | 64 | Channel driver enables |
| done | output | 1 | Run complete |

## Verification
The bound checker watches, on every cycle:
- that the bus stays quiet while the host owns it;
- that undriven channels read zero;
- that the marker channel is enabled whenever any channel is;
- that pattern data never changes without a marker toggle;
- that no step is shorter than the fetch time;
- that the block stays silent once done.

Only the bench's scenarios can show the rest, because each depends on knowing the memory contents and the programmed settings:
- the exact pattern values per step and the byte-to-channel order;
- the exact step lengths for long, boundary and short periods and around a host takeover;
- the done timing;
- that start and mask changes during a run are ignored.

// File: rtl/vgen_pkg.sv
package vgen_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_FIRST,
        SQ_RUN
    } seq_state_e;

    typedef struct packed {
        logic active;
        logic marker;
        logic done;
    } seq_flags_t;

    // cycles from a prefetch kick until the assembled pattern can be loaded
    function automatic int unsigned vg_fetch_latency(input int unsigned nbytes);
        return nbytes + 2;
    endfunction

endpackage

// File: rtl/vgen_bus_gate.sv
module vgen_bus_gate #(
    parameter int ADDR_W = 18
) (
    input  logic [1:0]        bus_sel,
    input  logic              req_rd,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              owner,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_drive
);

    always_comb begin
        owner     = |bus_sel;
        mem_drive = owner;
        mem_rd    = owner & req_rd;
        mem_addr  = owner ? req_addr : '0;
    end

endmodule

// File: rtl/vgen_fetch.sv
module vgen_fetch #(
    parameter int CH     = 64,
    parameter int BYTE_W = 8,
    parameter int BYTES  = 8,
    parameter int LANE_W = 3,
    parameter int VIDX_W = 15,
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              kick,
    input  logic [VIDX_W-1:0] kick_idx,
    input  logic              owner,
    input  logic              consume,
    input  logic [BYTE_W-1:0] rdata,
    output logic              req_rd,
    output logic [ADDR_W-1:0] req_addr,
    output logic              full,
    output logic [CH-2:0]     vec
);

    localparam logic [LANE_W:0] ISSUE_END = (LANE_W+1)'(BYTES);
    localparam logic [LANE_W:0] CAP_LAST  = (LANE_W+1)'(BYTES - 1);

    logic              busy_q;
    logic              full_q;
    logic              pend_q;
    logic [LANE_W-1:0] lane_q;
    logic [LANE_W:0]   issue_q;
    logic [LANE_W:0]   cap_q;
    logic [VIDX_W-1:0] idx_q;
    logic [CH-2:0]     asm_q;
    logic              fire;

    always_comb begin
        req_rd   = busy_q && (issue_q != ISSUE_END);
        req_addr = {idx_q, issue_q[LANE_W-1:0]};
        fire     = req_rd & owner;
        full     = full_q;
        vec      = asm_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            full_q  <= 1'b0;
            pend_q  <= 1'b0;
            lane_q  <= '0;
            issue_q <= '0;
            cap_q   <= '0;
            idx_q   <= '0;
        end else begin
            pend_q <= fire;
            lane_q <= issue_q[LANE_W-1:0];
            if (kick) begin
                busy_q  <= 1'b1;
                full_q  <= 1'b0;
                idx_q   <= kick_idx;
                issue_q <= '0;
                cap_q   <= '0;
            end else begin
                if (fire) begin
                    issue_q <= issue_q + 1'b1;
                end
                if (pend_q) begin
                    cap_q <= cap_q + 1'b1;
                    if (cap_q == CAP_LAST) begin
                        full_q <= 1'b1;
                        busy_q <= 1'b0;
                    end
                end
                if (consume) begin
                    full_q <= 1'b0;
                end
            end
        end
    end

    // byte lanes land least significant first; the top channel has no storage
    always_ff @(posedge clk) begin
        if (rst) begin
            asm_q <= '0;
        end else if (pend_q) begin
            for (int j = 0; j < CH - 1; j++) begin
                if (lane_q == LANE_W'(j / BYTE_W)) begin
                    asm_q[j] <= rdata[j % BYTE_W];
                end
            end
        end
    end

endmodule

// File: rtl/vgen_seq.sv
module vgen_seq
    import vgen_pkg::*;
#(
    parameter int PER_W  = 16,
    parameter int CNT_W  = 16,
    parameter int VIDX_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [PER_W-1:0]  period,
    input  logic [CNT_W-1:0]  nsteps,
    input  logic              full,
    output logic              accept,
    output logic              kick,
    output logic              load,
    output logic [VIDX_W-1:0] kick_idx,
    output seq_flags_t        flags
);

    seq_state_e       state_q;
    seq_flags_t       flags_q;
    logic [CNT_W-1:0] step_q;
    logic [CNT_W-1:0] n_q;
    logic [CNT_W-1:0] next_step;
    logic [PER_W-1:0] hold_q;
    logic [PER_W-1:0] per_q;
    logic [PER_W-1:0] per_eff;
    logic             at_end;

    always_comb begin
        per_eff   = (per_q == '0) ? PER_W'(1) : per_q;
        next_step = step_q + CNT_W'(1);
        at_end    = (state_q == SQ_RUN) && (hold_q == per_eff);
        accept    = start && (state_q == SQ_IDLE);
        load      = full && ((state_q == SQ_FIRST) || (at_end && (step_q != n_q)));
        kick      = (accept && (nsteps != '0)) || (load && (next_step < n_q));
        kick_idx  = accept ? '0 : next_step[VIDX_W-1:0];
        flags     = flags_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            flags_q <= '0;
            step_q  <= '0;
            n_q     <= '0;
            hold_q  <= '0;
            per_q   <= '0;
        end else if (accept) begin
            per_q        <= period;
            n_q          <= nsteps;
            step_q       <= '0;
            flags_q.done <= (nsteps == '0);
            state_q      <= (nsteps == '0) ? SQ_IDLE : SQ_FIRST;
        end else if (load) begin
            state_q        <= SQ_RUN;
            step_q         <= next_step;
            hold_q         <= PER_W'(1);
            flags_q.marker <= ~flags_q.marker;
            flags_q.active <= 1'b1;
        end else if (at_end && (step_q == n_q)) begin
            flags_q.done <= 1'b1;
            state_q      <= SQ_IDLE;
        end else if ((state_q == SQ_RUN) && (hold_q != per_eff)) begin
            hold_q <= hold_q + 1'b1;
        end
    end

endmodule

// File: rtl/vgen_pins.sv
module vgen_pins #(
    parameter int CH = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic          load,
    input  logic [CH-2:0] mask_in,
    input  logic [CH-2:0] vec_in,
    input  logic          active,
    input  logic          marker,
    output logic [CH-1:0] pin_out,
    output logic [CH-1:0] pin_oe
);

    logic [CH-2:0] mask_stage_q;
    logic [CH-2:0] mask_live_q;
    logic [CH-2:0] vec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_stage_q <= '0;
            mask_live_q  <= '0;
            vec_q        <= '0;
        end else begin
            if (accept) begin
                mask_stage_q <= mask_in;
            end
            if (load) begin
                mask_live_q <= mask_stage_q;
                vec_q       <= vec_in;
            end
        end
    end

    for (genvar i = 0; i < CH - 1; i++) begin : g_chan
        assign pin_oe[i]  = active & ~mask_live_q[i];
        assign pin_out[i] = pin_oe[i] & vec_q[i];
    end

    assign pin_oe[CH-1]  = active;
    assign pin_out[CH-1] = marker;

endmodule

// File: rtl/vgen_top.sv
module vgen_top
    import vgen_pkg::*;
#(
    parameter int CH     = 64,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 18,
    parameter int PER_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        bus_sel,
    input  logic              start,
    input  logic [CH-2:0]     dir_mask,
    input  logic [PER_W-1:0]  period,
    input  logic [ADDR_W-LANE_W:0] nsteps,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_drive,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [CH-1:0]     pin_out,
    output logic [CH-1:0]     pin_oe,
    output logic              done
);

    localparam int BYTES  = CH / BYTE_W;
    localparam int LANE_W = $clog2(BYTES);
    localparam int VIDX_W = ADDR_W - LANE_W;
    localparam int CNT_W  = VIDX_W + 1;

    logic              owner;
    logic              req_rd;
    logic [ADDR_W-1:0] req_addr;
    logic              full;
    logic [CH-2:0]     asm_vec;
    logic              accept;
    logic              kick;
    logic              load;
    logic [VIDX_W-1:0] kick_idx;
    seq_flags_t        flags;

    vgen_bus_gate #(.ADDR_W(ADDR_W)) u_gate (
        .bus_sel  (bus_sel),
        .req_rd   (req_rd),
        .req_addr (req_addr),
        .owner    (owner),
        .mem_rd   (mem_rd),
        .mem_addr (mem_addr),
        .mem_drive(mem_drive)
    );

    vgen_fetch #(
        .CH(CH), .BYTE_W(BYTE_W), .BYTES(BYTES),
        .LANE_W(LANE_W), .VIDX_W(VIDX_W), .ADDR_W(ADDR_W)
    ) u_fetch (
        .clk     (clk),
        .rst     (rst),
        .kick    (kick),
        .kick_idx(kick_idx),
        .owner   (owner),
        .consume (load),
        .rdata   (mem_rdata),
        .req_rd  (req_rd),
        .req_addr(req_addr),
        .full    (full),
        .vec     (asm_vec)
    );

    vgen_seq #(.PER_W(PER_W), .CNT_W(CNT_W), .VIDX_W(VIDX_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .period  (period),
        .nsteps  (nsteps),
        .full    (full),
        .accept  (accept),
        .kick    (kick),
        .load    (load),
        .kick_idx(kick_idx),
        .flags   (flags)
    );

    vgen_pins #(.CH(CH)) u_pins (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .load   (load),
        .mask_in(dir_mask),
        .vec_in (asm_vec),
        .active (flags.active),
        .marker (flags.marker),
        .pin_out(pin_out),
        .pin_oe (pin_oe)
    );

    assign done = flags.done;

endmodule

// File: rtl/vgen_checker.sv
module vgen_checker
    import vgen_pkg::*;
#(
    parameter int CH     = 64,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        bus_sel,
    input logic              mem_rd,
    input logic              mem_drive,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [CH-1:0]     pin_out,
    input logic [CH-1:0]     pin_oe,
    input logic              done
);

    localparam int          GAP_W     = 16;
    localparam logic [GAP_W-1:0] FETCH_CYC = GAP_W'(vg_fetch_latency(CH / BYTE_W));

    logic             mark_prev_q;
    logic             seen_q;
    logic [GAP_W-1:0] gap_q;
    logic             tog;

    assign tog = pin_out[CH-1] != mark_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mark_prev_q <= 1'b0;
            seen_q      <= 1'b0;
            gap_q       <= '0;
        end else begin
            mark_prev_q <= pin_out[CH-1];
            if (tog) begin
                seen_q <= 1'b1;
                gap_q  <= GAP_W'(1);
            end else if (gap_q != '1) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    // R2
    host_bus_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel == 2'b00) |-> (!mem_rd && !mem_drive && (mem_addr == '0)));

    // R4
    undriven_low_chk: assert property (@(posedge clk) disable iff (rst)
        ((pin_out & ~pin_oe) == '0));

    // R4
    marker_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        (|pin_oe) |-> pin_oe[CH-1]);

    // R3
    whole_vector_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(pin_out[CH-2:0]) |-> !$stable(pin_out[CH-1]));

    // R6
    min_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tog && seen_q) |-> (gap_q >= FETCH_CYC));

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_rd);

    // R5
    done_marker_chk: assert property (@(posedge clk) disable iff (rst)
        (done && $past(done)) |-> $stable(pin_out[CH-1]));

endmodule

bind vgen_top vgen_checker #(.CH(CH), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_sel  (bus_sel),
    .mem_rd   (mem_rd),
    .mem_drive(mem_drive),
    .mem_addr (mem_addr),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .done     (done)
);

// File: tb/vgen_top_bench.sv
module vgen_top_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_sel = 2'b01;
    logic        start = 1'b0;
    logic [62:0] dir_mask = '0;
    logic [15:0] period = '0;
    logic [15:0] nsteps = '0;
    logic [17:0] mem_addr;
    logic        mem_rd;
    logic        mem_drive;
    logic [7:0]  mem_rdata = '0;
    logic [63:0] pin_out;
    logic [63:0] pin_oe;
    logic        done;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    vgen_top u_vgen_top (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .start(start),
        .dir_mask(dir_mask), .period(period), .nsteps(nsteps),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_drive(mem_drive),
        .mem_rdata(mem_rdata), .pin_out(pin_out), .pin_oe(pin_oe), .done(done)
    );

    function automatic logic [7:0] mem_byte(input logic [17:0] a);
        logic [17:0] h;
        h = (a * 18'd29) ^ (a >> 5) ^ 18'h0005A;
        return h[7:0];
    endfunction

    // behavioural memory: data valid the cycle after a strobe
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem_byte(mem_addr);
    end

    function automatic logic [63:0] exp_vec(input int k);
        logic [63:0] v;
        for (int b = 0; b < 8; b++) v[8*b +: 8] = mem_byte(18'(8 * k + b));
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic t_reset;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(pin_oe == '0, "R1", pin_oe, 64'h0);
        chk(pin_out == '0 && done == 1'b0, "R1", {pin_out[62:0], done}, 64'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(mem_rd == 1'b0 && pin_oe == '0, "R1", {mem_rd, pin_oe[62:0]}, 64'h0);
        chk(mem_drive == 1'b1, "R2", 64'(mem_drive), 64'h1);
    endtask

    task automatic t_no_start;
        bit quiet = 1'b1;
        repeat (50) begin
            @(negedge clk);
            if (mem_rd || pin_oe != '0 || pin_out != '0) quiet = 1'b0;
        end
        chk(quiet, "R8", 64'(quiet), 64'h1);
    endtask

    task automatic t_zero_steps;
        @(negedge clk);
        nsteps = 16'd0; period = 16'd5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1, "R9", 64'(done), 64'h1);
        repeat (20) @(negedge clk);
        chk(pin_out == '0 && pin_oe == '0 && !mem_rd, "R9", pin_out | pin_oe, 64'h0);
    endtask

    task automatic run_case(input logic [62:0] mask, input int per, input int n,
                            input int pause_at, input int pause_len, input bit disturb);
        logic mark;
        int   cyc;
        int   exp_len;
        int   peff;
        bit   quiet;
        peff = (per == 0) ? 1 : per;
        @(negedge clk);
        dir_mask = mask; period = 16'(per); nsteps = 16'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R9", 64'(done), 64'h0);
        mark = pin_out[63];
        cyc = 0;
        for (int k = 0; k < n; k++) begin
            while (pin_out[63] == mark && cyc < 400) begin
                @(negedge clk);
                cyc++;
                if (start) start = 1'b0;
            end
            if (pin_out[63] == mark) begin
                chk(1'b0, "R5", 64'(cyc), 64'(k));
                return;
            end
            if (k > 0) begin
                if (pause_at == k - 1) begin
                    exp_len = pause_len + 10;
                    chk(cyc == exp_len, "R7", 64'(cyc), 64'(exp_len));
                end else begin
                    exp_len = (peff > 10) ? peff : 10;
                    chk(cyc == exp_len, "R6", 64'(cyc), 64'(exp_len));
                end
            end
            mark = pin_out[63];
            chk(pin_out[62:0] == (exp_vec(k)[62:0] & ~mask), "R3",
                64'(pin_out[62:0]), 64'(exp_vec(k)[62:0] & ~mask));
            chk(pin_oe == {1'b1, ~mask}, "R4", pin_oe, {1'b1, ~mask});
            cyc = 0;
            if (disturb && k == 0) begin
                dir_mask = ~mask;
                start = 1'b1;
            end
            if (k == pause_at) begin
                bus_sel = 2'b00;
                quiet = 1'b1;
                repeat (pause_len) begin
                    @(negedge clk);
                    cyc++;
                    if (mem_rd || mem_drive || mem_addr != '0) quiet = 1'b0;
                end
                chk(quiet, "R2", 64'(quiet), 64'h1);
                bus_sel = 2'b01;
            end
        end
        while (cyc < peff - 1) begin
            @(negedge clk);
            cyc++;
        end
        chk(done == 1'b0, "R9", 64'(done), 64'h0);
        @(negedge clk);
        chk(done == 1'b1, "R9", 64'(done), 64'h1);
        chk(pin_oe == {1'b1, ~mask} && pin_out[62:0] == (exp_vec(n - 1)[62:0] & ~mask),
            "R9", 64'(pin_out[62:0]), 64'(exp_vec(n - 1)[62:0] & ~mask));
        repeat (20) @(negedge clk);
        chk(pin_out[63] == mark, "R5", 64'(pin_out[63]), 64'(mark));
    endtask

    initial begin
        t_reset();
        t_no_start();
        t_zero_steps();
        run_case(63'h0, 12, 4, -1, 0, 1'b0);
        run_case(63'h70F0_0000_FFFF_00A5, 10, 3, -1, 0, 1'b0);
        run_case(63'h0000_0F0F_0000_3C3C, 3, 3, -1, 0, 1'b0);
        run_case(63'h1, 0, 2, -1, 0, 1'b0);
        run_case(63'h0, 16, 4, 1, 30, 1'b0);
        run_case(63'h00FF_0000_FF00_0000, 20, 3, -1, 0, 1'b1);
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule